// File: doc/BRIEF.md
# Pin Event Interrupt Detector with Stability Filter

This block watches a bank of general-purpose input pins and raises one interrupt line per pin. Each pin is first brought into the clock domain through a flop chain. It can then be passed through a stability filter that takes a new value only after the input has held steady for a set number of cycles. The filtered or unfiltered value, chosen per pin, drives four trigger detectors: rising edge, falling edge, level high and level low. Each detector has its own per-pin enable, and any combination of them may be on for the same pin.

A triggered detector sets a sticky pending bit for its pin. Software clears a pending bit by writing 1 to it. An enable register gates the pending bits onto the interrupt outputs, and a test register lets software set pending bits directly, exactly as a real event would. Access is through a simple register port: a write strobe with address and data, and a combinational read. The register map is fixed by this block: 0 pending, 1 interrupt enable, 2 test (reads 0), 3 rising enable, 4 falling enable, 5 level-high enable, 6 level-low enable, 7 filter enable, 8 conditioned pin value (read-only).

Top module: `pin_event_irq`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are 0, never unknown.
- R2: With bit n of the rising enable (address 3) set, a 0-to-1 change of the conditioned value of pin n sets pending bit n, and no other pending bit.
- R3: With bit n of the falling enable (address 4) set, a 1-to-0 change of the conditioned value of pin n sets pending bit n.
- R4: With bit n of the level-high enable (address 5) set, pending bit n is set on every cycle the conditioned value is 1, so a clear written while the level persists does not leave the bit at 0.
- R5: With bit n of the level-low enable (address 6) set, pending bit n is set while the conditioned value of pin n is 0.
- R6: Writing the pending register (address 0) clears exactly the bits written as 1. Bits written as 0 keep their value. A pending bit falls only through such a write.
- R7: Interrupt output n is 1 exactly when pending bit n and enable bit n (address 1) are both 1.
- R8: Writing the test register (address 2) sets the pending bits written as 1. The test register always reads 0.
- R9: With filter enable bit n (address 7) set, a pulse on pin n shorter than the stability length (16 cycles by default) changes neither the conditioned value nor any pending bit. A value held well beyond that length is taken.
- R10: With filter enable bit n clear, a pulse of a few cycles on pin n reaches the detectors.
- R11: Address 8 reads the conditioned value of every pin. This is the value the detectors see.
- R12: Pin changes with all four trigger enables clear for that pin leave its pending bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Pin inputs, may change asynchronously |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Read data for the addressed register |
| irq_o | output | NPINS | Per-pin interrupt outputs |

## Verification
The bench builds the block with its default values: 32 pins, a 16-cycle stability length and two synchronizer stages. Because of this the top pin (bit 31) and bit 0 can both be exercised through the test register. Pulses of 12 cycles and holds of 40 cycles fall on either side of the filter threshold without depending on exact edge counts. The short depth also lets the filtered and unfiltered paths be compared on neighbouring pins within a few hundred cycles.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int unsigned REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_PEND   = 4'd0,
        RA_IE     = 4'd1,
        RA_TEST   = 4'd2,
        RA_RISE   = 4'd3,
        RA_FALL   = 4'd4,
        RA_HIGH   = 4'd5,
        RA_LOW    = 4'd6,
        RA_FILTEN = 4'd7,
        RA_LEVEL  = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
    } trig_en_t;

    function automatic logic trig_hit(input trig_en_t en, input logic cur, input logic prev);
        return (en.rise &  cur & ~prev) |
               (en.fall & ~cur &  prev) |
               (en.high &  cur)         |
               (en.low  & ~cur);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stable_filter.sv
module stable_filter #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(CYCLES - 1);

    logic          cand_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cand_q <= 1'b0;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else if (d_i != cand_q) begin
            cand_q <= d_i;
            cnt_q  <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            out_q <= cand_q;
        end
    end

    assign q_o = out_q;
endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NPINS-1:0]     cond_i,
    input  trig_en_t [NPINS-1:0] en_i,
    output logic [NPINS-1:0]     hit_o
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= cond_i;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign hit_o[g] = trig_hit(en_i[g], cond_i[g], prev_q[g]);
    end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned STABLE_LEN  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_we_i,
    input  logic [3:0]        reg_addr_i,
    input  logic [NPINS-1:0]  reg_wdata_i,
    output logic [NPINS-1:0]  reg_rdata_o,
    output logic [NPINS-1:0]  irq_o
);
    logic [NPINS-1:0] pend_q, ie_q, rise_q, fall_q, high_q, low_q, filten_q;
    logic [NPINS-1:0] sync_w, filt_w, cond_w, hit_w;
    logic [NPINS-1:0] clr_w, inj_w;
    trig_en_t [NPINS-1:0] ten_w;
    reg_sel_e sel_w;

    assign sel_w = reg_sel_e'(reg_addr_i);

    pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (sync_w)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_filt
        stable_filter #(.CYCLES(STABLE_LEN)) u_flt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .d_i   (sync_w[g]),
            .q_o   (filt_w[g])
        );
        assign cond_w[g] = filten_q[g] ? filt_w[g] : sync_w[g];
        assign ten_w[g]  = '{rise: rise_q[g], fall: fall_q[g],
                             high: high_q[g], low: low_q[g]};
    end

    trig_detect #(.NPINS(NPINS)) u_det (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cond_i (cond_w),
        .en_i   (ten_w),
        .hit_o  (hit_w)
    );

    assign clr_w = (reg_we_i && sel_w == RA_PEND) ? reg_wdata_i : '0;
    assign inj_w = (reg_we_i && sel_w == RA_TEST) ? reg_wdata_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q   <= '0;
            ie_q     <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            high_q   <= '0;
            low_q    <= '0;
            filten_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_w) | hit_w | inj_w;
            if (reg_we_i) begin
                case (sel_w)
                    RA_IE:     ie_q     <= reg_wdata_i;
                    RA_RISE:   rise_q   <= reg_wdata_i;
                    RA_FALL:   fall_q   <= reg_wdata_i;
                    RA_HIGH:   high_q   <= reg_wdata_i;
                    RA_LOW:    low_q    <= reg_wdata_i;
                    RA_FILTEN: filten_q <= reg_wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel_w)
            RA_PEND:   reg_rdata_o = pend_q;
            RA_IE:     reg_rdata_o = ie_q;
            RA_RISE:   reg_rdata_o = rise_q;
            RA_FALL:   reg_rdata_o = fall_q;
            RA_HIGH:   reg_rdata_o = high_q;
            RA_LOW:    reg_rdata_o = low_q;
            RA_FILTEN: reg_rdata_o = filten_q;
            RA_LEVEL:  reg_rdata_o = cond_w;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = pend_q & ie_q;
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             reg_we_i,
    input logic [3:0]       reg_addr_i,
    input logic [NPINS-1:0] reg_wdata_i,
    input logic [NPINS-1:0] pend_q,
    input logic [NPINS-1:0] high_q,
    input logic [NPINS-1:0] cond_w,
    input logic [NPINS-1:0] filt_w,
    input logic [NPINS-1:0] sync_w,
    input logic [NPINS-1:0] irq_o
);
    logic [NPINS-1:0] clr_mask, inj_mask;
    assign clr_mask = (reg_we_i && reg_addr_i == 4'd0) ? reg_wdata_i : '0;
    assign inj_mask = (reg_we_i && reg_addr_i == 4'd2) ? reg_wdata_i : '0;

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (irq_o == '0 && pend_q == '0));

    p_only_clear_drops_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0));

    p_level_sets_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (($past(high_q & cond_w) & ~pend_q) == '0));

    p_inject_sets_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (inj_mask != '0) |=> ((pend_q & $past(inj_mask)) == $past(inj_mask)));

    p_filter_takes_stable_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((filt_w ^ $past(filt_w)) & (filt_w ^ $past(sync_w))) == '0));
endmodule

bind pin_event_irq pin_event_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .pend_q      (pend_q),
    .high_q      (high_q),
    .cond_w      (cond_w),
    .filt_w      (filt_w),
    .sync_w      (sync_w),
    .irq_o       (irq_o)
);

// File: tb/pin_event_irq_test.sv
module pin_event_irq_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pin;
    logic         we;
    logic [3:0]   addr;
    logic [N-1:0] wdata;
    logic [N-1:0] rdata;
    logic [N-1:0] irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pin_event_irq #(.NPINS(N), .STABLE_LEN(16), .SYNC_STAGES(2)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .pin_i       (pin),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clean();
        for (int a = 1; a <= 7; a++) if (a != 2) wr(4'(a), '0);
        pin = '0;
        tick(40);
        wr(4'd0, '1);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        for (int a = 0; a <= 8; a++) begin
            rd(4'(a), d);
            chk("R1 reg after reset", d, '0);
        end
        chk("R1 irq after reset", irq, '0);
    endtask

    task automatic t_rise();
        logic [N-1:0] d;
        wr(4'd3, 32'h0000_0008);
        wr(4'd1, '1);
        pin[3] = 1'b1; pin[5] = 1'b1;
        tick(5);
        rd(4'd0, d);
        chk("R2 rising sets only enabled pin", d, 32'h0000_0008);
        chk("R12 unenabled pin 5 stays clear", d & 32'h20, '0);
        chk("R7 irq follows pending and enable", irq, 32'h0000_0008);
        wr(4'd0, 32'hFFFF_FFF7);
        rd(4'd0, d);
        chk("R6 write 0 keeps bit", d, 32'h0000_0008);
        wr(4'd0, 32'h0000_0008);
        rd(4'd0, d);
        chk("R6 write 1 clears bit", d, '0);
        clean();
    endtask

    task automatic t_fall();
        logic [N-1:0] d;
        pin[3] = 1'b1;
        tick(5);
        wr(4'd4, 32'h0000_0008);
        wr(4'd0, '1);
        rd(4'd0, d);
        chk("R3 no event before falling", d, '0);
        pin[3] = 1'b0;
        tick(5);
        rd(4'd0, d);
        chk("R3 falling sets bit", d, 32'h0000_0008);
        clean();
    endtask

    task automatic t_level();
        logic [N-1:0] d;
        wr(4'd5, 32'h0000_0080);
        pin[7] = 1'b1;
        tick(5);
        rd(4'd0, d);
        chk("R4 level high sets bit", d, 32'h0000_0080);
        wr(4'd0, 32'h0000_0080);
        rd(4'd0, d);
        chk("R4 clear does not hold while high", d, 32'h0000_0080);
        pin[7] = 1'b0;
        tick(5);
        wr(4'd0, 32'h0000_0080);
        rd(4'd0, d);
        chk("R4 clear holds once level gone", d, '0);
        wr(4'd5, '0);
        wr(4'd6, 32'h0000_0001);
        tick(2);
        rd(4'd0, d);
        chk("R5 level low sets bit", d, 32'h0000_0001);
        clean();
    endtask

    task automatic t_mask_and_test();
        logic [N-1:0] d;
        wr(4'd2, 32'hA000_0001);
        rd(4'd0, d);
        chk("R8 test sets pending", d, 32'hA000_0001);
        rd(4'd2, d);
        chk("R8 test reads zero", d, '0);
        chk("R7 irq masked when disabled", irq, '0);
        wr(4'd1, 32'h8000_0000);
        tick(1);
        chk("R7 irq only enabled bit", irq, 32'h8000_0000);
        clean();
    endtask

    task automatic t_filter();
        logic [N-1:0] d;
        wr(4'd7, 32'h0000_0400);
        wr(4'd3, 32'h0000_0C00);
        pin[10] = 1'b1;
        tick(12);
        pin[10] = 1'b0;
        tick(40);
        rd(4'd0, d);
        chk("R9 short pulse filtered", d, '0);
        pin[10] = 1'b1;
        tick(8);
        rd(4'd8, d);
        chk("R11 level not yet taken", d & 32'h400, '0);
        tick(32);
        rd(4'd8, d);
        chk("R11 level shows held value", d, 32'h0000_0400);
        rd(4'd0, d);
        chk("R9 held value triggers", d, 32'h0000_0400);
        wr(4'd0, '1);
        pin[11] = 1'b1;
        tick(3);
        pin[11] = 1'b0;
        tick(5);
        rd(4'd0, d);
        chk("R10 unfiltered short pulse detected", d, 32'h0000_0800);
        clean();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; pin = '0; we = 1'b0; addr = '0; wdata = '0;
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_rise();
        t_fall();
        t_level();
        t_mask_and_test();
        t_filter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule